// File: doc/BRIEF.md
# Scan-Doubling Video Line Fetcher

This block turns a 512-pixel-wide, 2-bit-per-pixel framebuffer in shared DRAM into a 1024x768 raster at 60 Hz. It does not keep a whole line on chip. It asks a memory arbiter for 64-bit chunks just in time, and it keeps only two of them at once. Each chunk is two consecutive 32-bit words of one source line, so a source line is sixteen chunks. The chunks are turned into pixels, and each pixel is shown for two pixel clocks. This maps 512 source pixels onto 1024 output pixels.

Vertical scaling repeats a source line on 1, 2 or 3 consecutive output lines. A factor of 2 gives a 512x384 image. Because no line is stored, every repeated output line reads its source line from memory again. Memory traffic is therefore the same for every repeat factor.

If a chunk is late, the block shows pixel index 0 for that chunk and sets a sticky underrun flag. Responses that belong to a line that has already gone are thrown away, so the picture lines up again on its own. The index output feeds an external palette.

Top module: `scan_double_fetcher`

## Requirements
- R1: `hsync_n` is low for exactly H_SW clocks per line, starting H_ACT+H_FP clocks after the start of the line. `vsync_n` is low for exactly V_SW lines, starting at line V_ACT+V_FP. Both are high at all other times, including whenever `de` is high.
- R2: `de` is high exactly on the first H_ACT clocks of each of the first V_ACT lines of a frame. `pix` is 0 whenever `de` is low.
- R3: Output pixel h of a line shows source pixel h/2, so each source pixel appears twice in a row. Chunk c of source line s is requested at word address s*CHUNKS+c, where CHUNKS is the number of chunks per line. Chunk c holds source pixels c*P to c*P+P-1, with P = CHUNK_W/BPP. Pixel j of a chunk is the field of bits [CHUNK_W-1-j*BPP -: BPP], so the most significant field comes first.
- R4: `rep_sel` is sampled once per frame, in the last blanking line. The value 1, 2 or 3 is the repeat factor, and 0 acts as 1. Output line v then shows source line v/rep.
- R5: Every active output line issues all CHUNKS requests again, whatever the repeat factor. A frame therefore accepts V_ACT*CHUNKS requests.
- R6: `req_valid` is held, with `req_addr` stable, until `req_ready` is high. Back-pressure that still lets every chunk arrive in time leaves the picture exact.
- R7: When a chunk is needed and has not arrived, all pixels of that chunk are 0. `underrun` rises with the first such pixel and stays high until reset.
- R8: After a stall, responses that belong to abandoned fetches are discarded. The next frame fetched without a stall is pixel-exact.
- R9: While `rst` is high, the outputs are `de`=0, `hsync_n`=1, `vsync_n`=1, `pix`=0, `underrun`=0 and `req_valid`=0. The first clock after reset presents the last blanking line of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| rep_sel | input | 2 | Line repeat factor (0/1 = single, 2, 3) |
| req_valid | output | 1 | Chunk fetch request |
| req_ready | input | 1 | Arbiter accepts the request |
| req_addr | output | ADDR_W | Chunk address: source line * CHUNKS + chunk |
| rsp_valid | input | 1 | Returned chunk is valid (in request order) |
| rsp_data | input | CHUNK_W | Returned chunk data |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active-video window |
| pix | output | BPP | Pixel index |
| underrun | output | 1 | Sticky late-chunk flag |

## Verification
Two things can fall in the same cycle. One is the start of a new line's fetch, which flushes the buffer and resets the request counters. The other is the arrival or acceptance of a request that belongs to a line already abandoned. The bench provokes this by holding `req_ready` low across a frame boundary, so that an old request is still pending when the next prefetch begins, and by throttling `req_ready` in a frame of its own. The result is judged at the ports: the stalled frame must be all zeros with a raised `underrun`, and the following frame must match the arithmetic model pixel for pixel.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
  // Registered video control group travelling with each pixel.
  typedef struct packed {
    logic de;
    logic hs_n;
    logic vs_n;
  } sync_t;

  localparam logic [1:0] REP_ONE = 2'd1;
endpackage

// File: rtl/sdf_timing.sv
`timescale 1ns/1ps
module sdf_timing #(
  parameter int H_ACT = 1024,
  parameter int H_FP  = 24,
  parameter int H_SW  = 136,
  parameter int H_BP  = 160,
  parameter int V_ACT = 768,
  parameter int V_FP  = 3,
  parameter int V_SW  = 6,
  parameter int V_BP  = 29,
  parameter int HW    = $clog2(H_ACT + H_FP + H_SW + H_BP)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [HW-1:0]  hcnt,
  output sdf_pkg::sync_t vid,
  output logic           line_trig,
  output logic           frame_trig
);
  localparam int HT = H_ACT + H_FP + H_SW + H_BP;
  localparam int VT = V_ACT + V_FP + V_SW + V_BP;
  localparam int VW = $clog2(VT);

  logic [VW-1:0] vcnt;
  logic          at_blank_start;

  // Reset lands on the last blanking line so the first frame gets a prefetch.
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= VW'(VT - 1);
    end else if (hcnt == HW'(HT - 1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == VW'(VT - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    vid.de   = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
    vid.hs_n = !((hcnt >= HW'(H_ACT + H_FP)) && (hcnt < HW'(H_ACT + H_FP + H_SW)));
    vid.vs_n = !((vcnt >= VW'(V_ACT + V_FP)) && (vcnt < VW'(V_ACT + V_FP + V_SW)));
    at_blank_start = (hcnt == HW'(H_ACT));
    frame_trig = at_blank_start && (vcnt == VW'(VT - 1));
    line_trig  = at_blank_start && ((vcnt < VW'(V_ACT - 1)) || (vcnt == VW'(VT - 1)));
  end
endmodule

// File: rtl/sdf_chunk_buf.sv
`timescale 1ns/1ps
module sdf_chunk_buf #(
  parameter int W     = 64,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
endmodule

// File: rtl/sdf_fetch.sv
`timescale 1ns/1ps
module sdf_fetch #(
  parameter int V_ACT  = 768,
  parameter int CHUNKS = 16,
  parameter int DEPTH  = 2,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        rep_sel,
  input  logic              line_trig,
  input  logic              frame_trig,
  input  logic              load,
  input  logic              miss,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              keep
);
  localparam int LW = (V_ACT > 1) ? $clog2(V_ACT) : 1;
  localparam int KW = $clog2(CHUNKS + 1);
  localparam int DW = $clog2(DEPTH + CHUNKS + 1);
  localparam int IW = $clog2(4 * DEPTH) + 2;

  logic [1:0]    rep_q, rep_cnt;
  logic [LW-1:0] fetch_line;
  logic [KW-1:0] fetch_chunk;
  logic [DW-1:0] credits;
  logic [IW-1:0] inflight, inflight_n, drop;
  logic          acc, issue;

  assign acc        = req_valid && req_ready;
  assign inflight_n = inflight + IW'(acc) - IW'(rsp_valid);
  assign issue      = (!req_valid || req_ready) && !line_trig &&
                      (credits != '0) && (fetch_chunk < KW'(CHUNKS));
  assign keep       = rsp_valid && (drop == '0) && !line_trig;

  // Line bookkeeping: which source line the next displayed line needs.
  always_ff @(posedge clk) begin
    if (rst) begin
      rep_q      <= sdf_pkg::REP_ONE;
      rep_cnt    <= '0;
      fetch_line <= '0;
    end else if (frame_trig) begin
      rep_q      <= (rep_sel == 2'd0) ? sdf_pkg::REP_ONE : rep_sel;
      rep_cnt    <= '0;
      fetch_line <= '0;
    end else if (line_trig) begin
      if (rep_cnt == rep_q - 2'd1) begin
        rep_cnt    <= '0;
        fetch_line <= fetch_line + 1'b1;
      end else begin
        rep_cnt <= rep_cnt + 2'd1;
      end
    end
  end

  // Request issue with credit-based look-ahead.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid   <= 1'b0;
      req_addr    <= '0;
      fetch_chunk <= '0;
      credits     <= '0;
    end else begin
      if (!req_valid || req_ready) req_valid <= issue;
      if (issue) req_addr <= ADDR_W'(fetch_line) * ADDR_W'(CHUNKS) + ADDR_W'(fetch_chunk);
      if (line_trig) begin
        fetch_chunk <= '0;
        credits     <= DW'(DEPTH);
      end else begin
        fetch_chunk <= fetch_chunk + KW'(issue);
        credits     <= credits + DW'(load) - DW'(issue);
      end
    end
  end

  // Tracking of responses that belong to abandoned or missed chunks.
  always_ff @(posedge clk) begin
    if (rst) begin
      inflight <= '0;
      drop     <= '0;
    end else begin
      inflight <= inflight_n;
      if (line_trig)
        drop <= inflight_n + IW'(req_valid && !req_ready);
      else
        drop <= drop - IW'(rsp_valid && (drop != '0)) + IW'(miss);
    end
  end
endmodule

// File: rtl/sdf_shifter.sv
`timescale 1ns/1ps
module sdf_shifter #(
  parameter int CW  = 64,
  parameter int BPP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic [CW-1:0]  din,
  output logic [BPP-1:0] pix
);
  logic [CW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (load) sh <= din;
    else if (adv)  sh <= sh << BPP;
  end

  assign pix = load ? din[CW-1 -: BPP] : sh[CW-1 -: BPP];
endmodule

// File: rtl/scan_double_fetcher.sv
`timescale 1ns/1ps
module scan_double_fetcher #(
  parameter int H_ACT   = 1024,
  parameter int H_FP    = 24,
  parameter int H_SW    = 136,
  parameter int H_BP    = 160,
  parameter int V_ACT   = 768,
  parameter int V_FP    = 3,
  parameter int V_SW    = 6,
  parameter int V_BP    = 29,
  parameter int BPP     = 2,
  parameter int CHUNK_W = 64,
  parameter int DEPTH   = 2,
  parameter int ADDR_W  = $clog2(V_ACT * ((H_ACT / 2) * BPP / CHUNK_W))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         rep_sel,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  input  logic               rsp_valid,
  input  logic [CHUNK_W-1:0] rsp_data,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               de,
  output logic [BPP-1:0]     pix,
  output logic               underrun
);
  localparam int SRC_PIX = H_ACT / 2;
  localparam int PPC     = CHUNK_W / BPP;
  localparam int CHUNKS  = SRC_PIX * BPP / CHUNK_W;
  localparam int PH_W    = $clog2(2 * PPC);
  localparam int HW      = $clog2(H_ACT + H_FP + H_SW + H_BP);

  logic [HW-1:0]      hcnt;
  sdf_pkg::sync_t     vid, vid_q;
  logic               line_trig, frame_trig;
  logic               load, adv, keep, empty, hit, bypass, miss;
  logic [CHUNK_W-1:0] head, din;
  logic [BPP-1:0]     pix_c;
  logic [BPP-1:0]     pix_q;
  logic               underrun_q;

  sdf_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP), .HW(HW)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vid(vid),
    .line_trig(line_trig), .frame_trig(frame_trig)
  );

  // A chunk is taken on every 2*PPC-th clock of the active window.
  assign load   = vid.de && (hcnt[PH_W-1:0] == '0);
  assign adv    = vid.de && hcnt[0];
  assign hit    = load && !empty;
  assign bypass = load && empty && keep;
  assign miss   = load && empty && !keep;
  assign din    = miss ? '0 : (empty ? rsp_data : head);

  sdf_fetch #(
    .V_ACT(V_ACT), .CHUNKS(CHUNKS), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .rep_sel(rep_sel),
    .line_trig(line_trig), .frame_trig(frame_trig),
    .load(load), .miss(miss), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .req_valid(req_valid), .req_addr(req_addr), .keep(keep)
  );

  sdf_chunk_buf #(.W(CHUNK_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush(line_trig),
    .wr_en(keep && !bypass), .wr_data(rsp_data),
    .rd_en(hit), .rd_data(head), .empty(empty)
  );

  sdf_shifter #(.CW(CHUNK_W), .BPP(BPP)) u_shift (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .din(din), .pix(pix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q      <= '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};
      pix_q      <= '0;
      underrun_q <= 1'b0;
    end else begin
      vid_q      <= vid;
      pix_q      <= vid.de ? pix_c : '0;
      underrun_q <= underrun_q || miss;
    end
  end

  assign de       = vid_q.de;
  assign hsync_n  = vid_q.hs_n;
  assign vsync_n  = vid_q.vs_n;
  assign pix      = pix_q;
  assign underrun = underrun_q;
endmodule

// File: rtl/scan_double_fetcher_chk.sv
`timescale 1ns/1ps
module scan_double_fetcher_chk #(
  parameter int BPP    = 2,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              de,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic [BPP-1:0]    pix,
  input logic              underrun,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr
);
  AST_BLANK_PIX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix == '0)); // R2

  AST_SYNC_IDLE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R7
endmodule

bind scan_double_fetcher scan_double_fetcher_chk #(.BPP(BPP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .pix(pix), .underrun(underrun), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr)
);

// File: tb/scan_double_fetcher_tb.sv
`timescale 1ns/1ps
module scan_double_fetcher_tb;
  localparam int H_ACT = 16, H_FP = 2, H_SW = 3, H_BP = 3;
  localparam int V_ACT = 6,  V_FP = 1, V_SW = 2, V_BP = 1;
  localparam int BPP = 2, CW = 8, DEPTH = 2, LAT = 3;
  localparam int HT = H_ACT + H_FP + H_SW + H_BP;
  localparam int VT = V_ACT + V_FP + V_SW + V_BP;
  localparam int P = CW / BPP;
  localparam int CHUNKS = (H_ACT / 2) * BPP / CW;
  localparam int AW = $clog2(V_ACT * CHUNKS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rep_sel;
  logic req_valid, req_ready, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] rsp_data;
  logic hsync_n, vsync_n, de, underrun;
  logic [BPP-1:0] pix;

  int tests = 0;
  int fails = 0;
  int acc_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scan_double_fetcher #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .BPP(BPP), .CHUNK_W(CW), .DEPTH(DEPTH)
  ) u_dut (
    .clk(clk), .rst(rst), .rep_sel(rep_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pix(pix), .underrun(underrun)
  );

  function automatic logic [CW-1:0] mem_word(int a);
    return CW'(a * 29 + 77);
  endfunction

  function automatic logic [1:0] rep_for(int f);
    case (f)
      2: return 2'd2;
      3: return 2'd3;
      4: return 2'd0;
      5: return 2'd2;
      7: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // Fixed-latency memory model answering in request order.
  logic          pv [LAT];
  logic [CW-1:0] pd [LAT];
  initial for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; end
  always @(posedge clk) begin
    pv[0] <= req_valid && req_ready && !rst;
    pd[0] <= mem_word(int'(req_addr));
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
  end
  assign rsp_valid = pv[LAT-1];
  assign rsp_data  = pd[LAT-1];

  task automatic chk(bit ok, string req, int t, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, got, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int t;
    rep_sel   = rep_for(1);
    req_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(de == 1'b0,        "R9", -1, de, 0);
    chk(hsync_n == 1'b1,   "R9", -1, hsync_n, 1);
    chk(vsync_n == 1'b1,   "R9", -1, vsync_n, 1);
    chk(pix == '0,         "R9", -1, pix, 0);
    chk(underrun == 1'b0,  "R9", -1, underrun, 0);
    chk(req_valid == 1'b0, "R9", -1, req_valid, 0);
    rst = 1'b0;
    t = 0;
    while (1) begin
      int lin, v, h, frame, rep, src, chunk, j, e_pix;
      bit e_de, e_hs, e_vs, e_ur;
      string tag;
      @(posedge clk);
      @(negedge clk);
      lin   = t / HT + VT - 1;
      v     = lin % VT;
      frame = lin / VT;
      h     = t % HT;
      if (frame == 8) break;
      e_de = (h < H_ACT) && (v < V_ACT);
      e_hs = !((h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SW));
      e_vs = !((v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SW));
      e_ur = (frame >= 6);
      rep  = (rep_for(frame) == 2'd0) ? 1 : int'(rep_for(frame));
      e_pix = 0;
      if (e_de && frame != 6) begin
        src   = v / rep;
        chunk = (h / 2) / P;
        j     = (h / 2) % P;
        e_pix = int'((mem_word(src * CHUNKS + chunk) >> (CW - BPP * (j + 1))) & 8'h3);
      end
      case (frame)
        5: tag = "R6";
        6: tag = "R7";
        7: tag = "R8";
        default: tag = (rep == 1) ? "R3" : "R4";
      endcase
      chk(hsync_n == e_hs, "R1", t, hsync_n, int'(e_hs));
      chk(vsync_n == e_vs, "R1", t, vsync_n, int'(e_vs));
      chk(de == e_de,      "R2", t, de, int'(e_de));
      chk(int'(pix) == e_pix, tag, t, pix, e_pix);
      chk(underrun == e_ur, "R7", t, underrun, int'(e_ur));
      // R5: requests accepted from frame 1 prefetch through end of frame 4
      if (req_valid && req_ready && lin >= VT - 1 && lin <= 5 * VT - 2) acc_cnt++;
      // stimulus for following cycles
      if (v == 0 && h == 0) rep_sel = rep_for(frame + 1);
      if ((frame == 5 && v >= V_ACT) || (frame == 6 && v < V_ACT)) req_ready = 1'b0;
      else if (frame == 5) req_ready = (t % 3 != 0);
      else req_ready = 1'b1;
      t++;
    end
    chk(acc_cnt == 4 * V_ACT * CHUNKS, "R5", t, acc_cnt, 4 * V_ACT * CHUNKS);
    done = 1'b1;
    summary();
  end
endmodule